// File: doc/BRIEF.md
# Dual-Channel Interrupt Gate and Card Identity Registers

This block is the register front end of a two-channel disk interface card. It sits on a synchronous byte bus and gates the interrupt request coming from each drive channel. Each channel has its own mask-control address: a write of any data to it turns that channel's interrupt on, and a read of it turns the interrupt off. Each channel also has a status byte that shows in bit 0 whether that channel's drive is requesting service, whether or not the channel is enabled.

One card interrupt line goes to the host. It is the OR, across channels, of each raw request qualified by that channel's enable flop. A four-bit card type code, taken from strap inputs, can be read back one bit at a time from four addresses spaced four bytes apart. A control byte at address zero picks which channel the single shared DMA engine serves (bit 0) and opens the drive register window (a parameter-chosen bit). Writing zero to it returns the card to its quiet default state.

Top module: `dual_chan_irq_regs`

## Requirements
- R1: After reset every channel enable is off, irq_out is 0, the control byte is 0 (so dma_chan_sel and win_open are 0), and bus_rdata is 0.
- R2: A write with any data to channel 1's mask address 0x2200 or channel 2's mask address 0x3200 sets that channel's enable; it stays set until a read of the same address.
- R3: A read of a channel's mask address clears that channel's enable and returns 0x00 on bus_rdata.
- R4: When bus_wr and bus_rd are both high at a mask address in one cycle, the enable ends set (the write wins).
- R5: A read of a status address (0x2290 for channel 1, 0x3290 for channel 2) returns that channel's raw request in bit 0, with bits 7..1 at 0, regardless of the enable.
- R6: irq_out is 1 exactly when some channel has both its request and its enable high; it follows chan_req without a clock delay.
- R7: A read of 0x2280 + 4*k, for k in 0..3, returns bit k of type_code in bit 0 with bits 7..1 at 0.
- R8: A write to address 0x0000 stores the whole byte in the control register; dma_chan_sel is bit 0 (0 selects channel 1, 1 selects channel 2), win_open is bit 2, and a read of 0x0000 returns the stored byte. Writing 0x00 clears both outputs.
- R9: Reads of unmapped addresses (including status and ID addresses plus one) return 0x00; writes to unmapped, status or ID addresses change neither the control byte nor any enable.
- R10: Read data appears on bus_rdata in the cycle after the read strobe and is 0x00 in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_rdata | output | 8 | Registered read data, one cycle after bus_rd |
| chan_req | input | 2 | Raw interrupt request from each drive channel |
| type_code | input | 4 | Strapped card type code |
| irq_out | output | 1 | Combined, enable-qualified card interrupt |
| dma_chan_sel | output | 1 | Channel served by the DMA engine |
| win_open | output | 1 | Drive register window open |

## Verification
The bench builds the block with its default parameters: two channels, a four-bit type code and the window-open flag on control bit 2. With those values both mask addresses, both status addresses, all four ID addresses and the control byte are reachable, so the bench can drive each channel's request alone and together, toggle enables in every order including a same-cycle read and write, and step the type code through a pattern with mixed ones and zeros. Neighbouring unmapped addresses one byte off each decoded location are probed to show that decode is exact.

// File: rtl/dcirq_pkg.sv
package dcirq_pkg;
    localparam int unsigned ADDR_W      = 16;
    localparam int unsigned DATA_W      = 8;
    localparam int unsigned MASK_BASE   = 32'h2200;
    localparam int unsigned STAT_BASE   = 32'h2290;
    localparam int unsigned CHAN_STRIDE = 32'h1000;
    localparam int unsigned ID_BASE     = 32'h2280;
    localparam int unsigned ID_STRIDE   = 32'h0004;
    localparam int unsigned CTL_ADDR    = 32'h0000;
endpackage

// File: rtl/dcirq_dec.sv
module dcirq_dec
    import dcirq_pkg::*;
#(
    parameter int unsigned N_CHAN  = 2,
    parameter int unsigned ID_BITS = 4
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [N_CHAN-1:0]  mask_hit,
    output logic [N_CHAN-1:0]  stat_hit,
    output logic [ID_BITS-1:0] id_hit,
    output logic               ctl_hit
);
    for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
        localparam logic [ADDR_W-1:0] M_ADDR = ADDR_W'(MASK_BASE + i * CHAN_STRIDE);
        localparam logic [ADDR_W-1:0] S_ADDR = ADDR_W'(STAT_BASE + i * CHAN_STRIDE);
        assign mask_hit[i] = (addr == M_ADDR);
        assign stat_hit[i] = (addr == S_ADDR);
    end

    for (genvar k = 0; k < ID_BITS; k++) begin : g_id
        localparam logic [ADDR_W-1:0] I_ADDR = ADDR_W'(ID_BASE + k * ID_STRIDE);
        assign id_hit[k] = (addr == I_ADDR);
    end

    assign ctl_hit = (addr == ADDR_W'(CTL_ADDR));
endmodule

// File: rtl/dcirq_chan.sv
module dcirq_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic clr_en,
    input  logic req,
    output logic en,
    output logic gated
);
    typedef struct packed {
        logic en;
    } chan_state_t;

    chan_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_en) begin
            st_d.en = 1'b1;
        end else if (clr_en) begin
            st_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en    = st_q.en;
    assign gated = req & st_q.en;
endmodule

// File: rtl/dcirq_rdmux.sv
module dcirq_rdmux
    import dcirq_pkg::*;
#(
    parameter int unsigned N_CHAN  = 2,
    parameter int unsigned ID_BITS = 4
) (
    input  logic [N_CHAN-1:0]  stat_hit,
    input  logic [ID_BITS-1:0] id_hit,
    input  logic               ctl_hit,
    input  logic [N_CHAN-1:0]  req,
    input  logic [ID_BITS-1:0] type_code,
    input  logic [DATA_W-1:0]  ctl_val,
    output logic [DATA_W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_CHAN; i++) begin
            if (stat_hit[i]) begin
                rdata = DATA_W'(req[i]);
            end
        end
        for (int k = 0; k < ID_BITS; k++) begin
            if (id_hit[k]) begin
                rdata = DATA_W'(type_code[k]);
            end
        end
        if (ctl_hit) begin
            rdata = ctl_val;
        end
    end
endmodule

// File: rtl/dual_chan_irq_regs.sv
module dual_chan_irq_regs
    import dcirq_pkg::*;
#(
    parameter int unsigned N_CHAN     = 2,
    parameter int unsigned ID_BITS    = 4,
    parameter int unsigned WIN_EN_BIT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [N_CHAN-1:0]    chan_req,
    input  logic [ID_BITS-1:0]   type_code,
    output logic                 irq_out,
    output logic                 dma_chan_sel,
    output logic                 win_open
);
    typedef struct packed {
        logic [DATA_W-1:0] ctl;
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [N_CHAN-1:0]  mask_hit;
    logic [N_CHAN-1:0]  stat_hit;
    logic [ID_BITS-1:0] id_hit;
    logic               ctl_hit;
    logic [N_CHAN-1:0]  en_q;
    logic [N_CHAN-1:0]  gated;
    logic [DATA_W-1:0]  rd_val;

    dcirq_dec #(.N_CHAN(N_CHAN), .ID_BITS(ID_BITS)) u_dec (
        .addr     (bus_addr),
        .mask_hit (mask_hit),
        .stat_hit (stat_hit),
        .id_hit   (id_hit),
        .ctl_hit  (ctl_hit)
    );

    for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
        dcirq_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_en (bus_wr & mask_hit[i]),
            .clr_en (bus_rd & mask_hit[i]),
            .req    (chan_req[i]),
            .en     (en_q[i]),
            .gated  (gated[i])
        );
    end

    dcirq_rdmux #(.N_CHAN(N_CHAN), .ID_BITS(ID_BITS)) u_mux (
        .stat_hit  (stat_hit),
        .id_hit    (id_hit),
        .ctl_hit   (ctl_hit),
        .req       (chan_req),
        .type_code (type_code),
        .ctl_val   (st_q.ctl),
        .rdata     (rd_val)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rdata = bus_rd ? rd_val : '0;
        if (bus_wr && ctl_hit) begin
            st_d.ctl = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata    = st_q.rdata;
    assign irq_out      = |gated;
    assign dma_chan_sel = st_q.ctl[0];
    assign win_open     = st_q.ctl[WIN_EN_BIT];
endmodule

// File: rtl/dcirq_chk.sv
module dcirq_chk
    import dcirq_pkg::*;
#(
    parameter int unsigned N_CHAN = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wr,
    input logic              rd,
    input logic [DATA_W-1:0] rdata,
    input logic [N_CHAN-1:0] req,
    input logic [N_CHAN-1:0] en,
    input logic              irq,
    input logic              dsel
);
    for (genvar i = 0; i < N_CHAN; i++) begin : g_c
        localparam logic [ADDR_W-1:0] M_A = ADDR_W'(MASK_BASE + i * CHAN_STRIDE);
        localparam logic [ADDR_W-1:0] S_A = ADDR_W'(STAT_BASE + i * CHAN_STRIDE);

        a_r2_write_enables: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && addr == M_A) |=> en[i]);
        a_r3_read_disables: assert property (@(posedge clk) disable iff (!rst_n)
            (rd && !wr && addr == M_A) |=> !en[i]);
        a_r3_mask_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (rd && addr == M_A) |=> rdata == '0);
        a_r5_status_bit: assert property (@(posedge clk) disable iff (!rst_n)
            (rd && addr == S_A) |=> rdata == DATA_W'($past(req[i])));
    end

    a_r6_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);
    a_r8_dma_select: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(CTL_ADDR)) |=> dsel == $past(wdata[0]));
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> rdata == '0);
endmodule

bind dual_chan_irq_regs dcirq_chk #(.N_CHAN(N_CHAN)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .wr    (bus_wr),
    .rd    (bus_rd),
    .rdata (bus_rdata),
    .req   (chan_req),
    .en    (en_q),
    .irq   (irq_out),
    .dsel  (dma_chan_sel)
);

// File: tb/sim_dual_chan_irq_regs.sv
module sim_dual_chan_irq_regs;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [1:0] chan_req = '0;
    logic [3:0] type_code = '0;
    logic       irq_out;
    logic       dma_chan_sel;
    logic       win_open;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    dual_chan_irq_regs u0 (
        .clk (clk), .rst_n (rst_n),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_rdata (bus_rdata),
        .chan_req (chan_req), .type_code (type_code),
        .irq_out (irq_out), .dma_chan_sel (dma_chan_sel), .win_open (win_open)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rdwr_reg(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic irq_is(logic [1:0] r, logic exp, string req);
        chan_req = r;
        #1;
        check(req, {7'b0, irq_out}, {7'b0, exp});
    endtask

    task automatic t_reset;
        check("R1 irq", {7'b0, irq_out}, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 dma_sel", {7'b0, dma_chan_sel}, 8'h00);
        check("R1 win", {7'b0, win_open}, 8'h00);
        irq_is(2'b11, 1'b0, "R1 enables off");
    endtask

    task automatic t_status;
        logic [7:0] v;
        chan_req = 2'b01;
        rd_reg(16'h2290, v); check("R5 ch1 pending", v, 8'h01);
        rd_reg(16'h3290, v); check("R5 ch2 idle", v, 8'h00);
        chan_req = 2'b10;
        rd_reg(16'h2290, v); check("R5 ch1 idle", v, 8'h00);
        rd_reg(16'h3290, v); check("R5 ch2 pending", v, 8'h01);
    endtask

    task automatic t_enable;
        logic [7:0] v;
        wr_reg(16'h2200, 8'h00);
        irq_is(2'b01, 1'b1, "R2 ch1 enabled");
        irq_is(2'b10, 1'b0, "R6 ch2 still masked");
        wr_reg(16'h3200, 8'hA5);
        irq_is(2'b10, 1'b1, "R2 ch2 enabled");
        irq_is(2'b00, 1'b0, "R6 no request");
        irq_is(2'b11, 1'b1, "R6 both");
        rd_reg(16'h2200, v);
        check("R3 mask read data", v, 8'h00);
        irq_is(2'b01, 1'b0, "R3 ch1 disabled");
        irq_is(2'b10, 1'b1, "R3 ch2 untouched");
        rd_reg(16'h3200, v);
        irq_is(2'b10, 1'b0, "R3 ch2 disabled");
        rdwr_reg(16'h3200, 8'h00);
        irq_is(2'b10, 1'b1, "R4 write wins");
        rd_reg(16'h3200, v);
        irq_is(2'b10, 1'b0, "R3 ch2 off again");
    endtask

    task automatic t_ident;
        logic [7:0] v;
        type_code = 4'b1010;
        rd_reg(16'h2280, v); check("R7 id bit0", v, 8'h00);
        rd_reg(16'h2284, v); check("R7 id bit1", v, 8'h01);
        rd_reg(16'h2288, v); check("R7 id bit2", v, 8'h00);
        rd_reg(16'h228C, v); check("R7 id bit3", v, 8'h01);
        type_code = 4'b0101;
        rd_reg(16'h2280, v); check("R7 id bit0 set", v, 8'h01);
        rd_reg(16'h228C, v); check("R7 id bit3 clr", v, 8'h00);
    endtask

    task automatic t_control;
        logic [7:0] v;
        wr_reg(16'h0000, 8'h05);
        check("R8 dma_sel ch2", {7'b0, dma_chan_sel}, 8'h01);
        check("R8 win open", {7'b0, win_open}, 8'h01);
        rd_reg(16'h0000, v); check("R8 readback", v, 8'h05);
        wr_reg(16'h0000, 8'h00);
        check("R8 dma_sel ch1", {7'b0, dma_chan_sel}, 8'h00);
        check("R8 win closed", {7'b0, win_open}, 8'h00);
        wr_reg(16'h0000, 8'h3C);
    endtask

    task automatic t_unmapped;
        logic [7:0] v;
        chan_req = 2'b11;
        rd_reg(16'h2201, v); check("R9 read 2201", v, 8'h00);
        rd_reg(16'h2291, v); check("R9 read 2291", v, 8'h00);
        rd_reg(16'h2281, v); check("R9 read 2281", v, 8'h00);
        rd_reg(16'h0001, v); check("R9 read 0001", v, 8'h00);
        wr_reg(16'h2290, 8'hFF);
        wr_reg(16'h2284, 8'hFF);
        wr_reg(16'h0001, 8'hFF);
        wr_reg(16'h2201, 8'hFF);
        irq_is(2'b11, 1'b0, "R9 enables unchanged");
        rd_reg(16'h0000, v); check("R9 ctl unchanged", v, 8'h3C);
    endtask

    task automatic t_timing;
        logic [7:0] v;
        rd_reg(16'h0000, v);
        check("R10 data after strobe", v, 8'h3C);
        @(negedge clk);
        check("R10 idle zero", bus_rdata, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status();
        t_enable();
        t_ident();
        t_control();
        t_unmapped();
        t_timing();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule